// File: doc/BRIEF.md
# Two-branch concatenated parity product encoder

The block turns a block of (n-1)^d serial data bits into one codeword that carries two independent protections. The data bits are treated as a d-dimensional cube with n-1 bits along each side. Branch A extends every axis of that cube with an even-parity bit, so its coded cube has n bits per side and n^d bits in total, including checks on checks. Branch B builds the same kind of product code over a permuted copy of the same data bits, using a fixed permutation table set at elaboration. The data is sent once, followed by the parity bits of branch A and then the parity bits of branch B. A codeword therefore holds 2n^d-(n-1)^d bits.

Data enters one bit per valid/ready handshake. The parity bits of both branches are accumulated as the bits arrive, and each data bit is also held so it can be sent again. The codeword leaves one bit per valid/ready handshake, and a last flag marks its final bit. The controller has five named states. IDLE waits for the first bit. LOAD collects the remaining bits. SEND_DATA, SEND_PAR_A and SEND_PAR_B emit the three sections. The transitions are: IDLE to LOAD on the first accepted bit (straight to SEND_DATA when a block is one bit long); LOAD to SEND_DATA on the last accepted data bit; SEND_DATA to SEND_PAR_A, and SEND_PAR_A to SEND_PAR_B, when the last bit of the section is taken; SEND_PAR_B back to IDLE when the bit carrying the last flag is taken; and any state to IDLE on reset. Elaboration stops if the permutation table does not list every data position exactly once.

Top module: `spc_pcc_encoder`

## Requirements
- R1: After the synchronous active-high reset, `in_ready` is 1 and `out_valid` and `out_last` are 0.
- R2: `in_ready` is 1 only in IDLE and LOAD. After the (n-1)^d-th data bit is accepted it falls to 0, and it stays at 0 until the bit flagged last has been taken at the output.
- R3: Each codeword has exactly 2n^d-(n-1)^d output bits, and `out_last` is 1 on the final bit only (bit 13 with the default n=3, d=2).
- R4: The first (n-1)^d output bits repeat the data bits in the order they arrived. Input position p has axis coordinates given by the base-(n-1) digits of p, with axis 0 the least significant.
- R5: Next come the branch-A parity bits, in raster order over the coded cube (base-n digits, axis 0 least significant), skipping positions that hold data. A parity bit with coordinate n-1 on a set S of axes is the XOR of the data bits that match its other coordinates. With the defaults the section is d0^d1, d2^d3, d0^d2, d1^d3, d0^d1^d2^d3.
- R6: Last come the branch-B parity bits, built in the same way over the sequence e[j] = data[PERM[j]], where PERM entry j sits in bits [8j+7:8j]. The default table is (2,0,3,1), so the section is d0^d2, d1^d3, d2^d3, d0^d1, d0^d1^d2^d3.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_bit` and `out_last` hold their values and `out_valid` stays 1.
- R8: `in_valid` and `in_bit` driven while `in_ready` is 0 have no effect on the current codeword or on the next one.
- R9: A reset in the middle of a block discards the data bits already collected, so the next block encodes as if it were the first.
- R10: Idle cycles between input bits, with `in_valid` at 0, do not change the codeword.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A data bit is offered |
| in_bit | input | 1 | The offered data bit |
| in_ready | output | 1 | The block can take a data bit |
| out_valid | output | 1 | A codeword bit is presented |
| out_bit | output | 1 | The presented codeword bit |
| out_last | output | 1 | The presented bit ends the codeword |
| out_ready | input | 1 | The sink takes the presented bit |

## Verification
If a parity accumulator holds a wrong value, one specific parity bit of the codeword comes out wrong. The error shows at the position of that bit, which is at most 2n^d-(n-1)^d handshakes after the block was loaded. If the section counter or the state goes wrong, the shape of the stream changes: the last flag moves, `in_ready` comes back early, or the data echo is misordered. The data echo appears within (n-1)^d output handshakes, and the flag shows within one codeword. A leftover that a reset or the final handshake should have cleared is wrong only in the following block, so the bench sends blocks back to back and also resets in the middle of a block.

// File: rtl/spc_pcc_pkg.sv
package spc_pcc_pkg;

    localparam int ENTRY_W     = 8;
    localparam int MAX_ENTRIES = 256;
    localparam int TABLE_W     = ENTRY_W * MAX_ENTRIES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SEND_DATA,
        ST_SEND_PAR_A,
        ST_SEND_PAR_B
    } enc_state_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_DATA,
        SRC_PAR_A,
        SRC_PAR_B
    } out_src_t;

    function automatic int ipow(input int base, input int expo);
        int acc;
        acc = 1;
        for (int i = 0; i < expo; i++) acc = acc * base;
        return acc;
    endfunction

    function automatic int table_entry(input logic [TABLE_W-1:0] tbl, input int j);
        return int'(tbl[j*ENTRY_W +: ENTRY_W]);
    endfunction

    // every position below cnt must appear exactly once
    function automatic logic table_is_perm(input logic [TABLE_W-1:0] tbl, input int cnt);
        int hits;
        if (cnt > MAX_ENTRIES) return 1'b0;
        for (int p = 0; p < cnt; p++) begin
            hits = 0;
            for (int j = 0; j < cnt; j++)
                if (table_entry(tbl, j) == p) hits++;
            if (hits != 1) return 1'b0;
        end
        return 1'b1;
    endfunction

    // branch-B slot that carries arriving data position p
    function automatic int table_inverse(input logic [TABLE_W-1:0] tbl, input int cnt,
                                         input int p);
        for (int j = 0; j < cnt; j++)
            if (table_entry(tbl, j) == p) return j;
        return 0;
    endfunction

    function automatic logic raster_is_data(input int r, input int n, input int d);
        int v;
        v = r;
        for (int a = 0; a < d; a++) begin
            if (v % n == n - 1) return 1'b0;
            v = v / n;
        end
        return 1'b1;
    endfunction

    // raster index of the idx-th parity bit of a coded cube
    function automatic int parity_raster(input int idx, input int n, input int d);
        int seen;
        seen = 0;
        for (int r = 0; r < ipow(n, d); r++) begin
            if (!raster_is_data(r, n, d)) begin
                if (seen == idx) return r;
                seen++;
            end
        end
        return 0;
    endfunction

    // parity at raster r covers data position p
    function automatic logic line_covers(input int r, input int p, input int n, input int d);
        int vr;
        int vp;
        vr = r;
        vp = p;
        for (int a = 0; a < d; a++) begin
            if ((vr % n != n - 1) && (vr % n != vp % (n - 1))) return 1'b0;
            vr = vr / n;
            vp = vp / (n - 1);
        end
        return 1'b1;
    endfunction

endpackage

// File: rtl/spc_parity_acc.sv
module spc_parity_acc
    import spc_pcc_pkg::*;
#(
    parameter int                 N_SIDE      = 3,
    parameter int                 DIMS        = 2,
    parameter bit                 INTERLEAVED = 1'b0,
    parameter logic [TABLE_W-1:0] PERM        = '0,
    parameter int                 CW          = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                upd,
    input  logic [CW-1:0]       pos,
    input  logic                bit_in,
    output logic [(1<<CW)-1:0]  par_o
);

    localparam int NDATA = ipow(N_SIDE - 1, DIMS);
    localparam int NPAR  = ipow(N_SIDE, DIMS) - NDATA;
    localparam int SPAN  = 1 << CW;

    logic [NPAR-1:0] acc_q;
    logic [NPAR-1:0] acc_d;

    for (genvar k = 0; k < NPAR; k++) begin : g_par
        localparam int RASTER = parity_raster(k, N_SIDE, DIMS);
        logic [SPAN-1:0] hit;
        for (genvar p = 0; p < SPAN; p++) begin : g_pos
            if (p < NDATA) begin : g_live
                localparam int SLOT = INTERLEAVED ? table_inverse(PERM, NDATA, p) : p;
                assign hit[p] = line_covers(RASTER, SLOT, N_SIDE, DIMS);
            end else begin : g_pad
                assign hit[p] = 1'b0;
            end
        end
        assign acc_d[k] = acc_q[k] ^ (upd & bit_in & hit[pos]);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) acc_q <= '0;
        else            acc_q <= acc_d;
    end

    if (NPAR == SPAN) begin : g_full
        assign par_o = acc_q;
    end else begin : g_pad_out
        assign par_o = {{(SPAN-NPAR){1'b0}}, acc_q};
    end

endmodule

// File: rtl/spc_pcc_ctrl.sv
module spc_pcc_ctrl
    import spc_pcc_pkg::*;
#(
    parameter int NDATA = 4,
    parameter int NPAR  = 5,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          out_ready,
    output logic          in_ready,
    output logic          out_valid,
    output logic          out_last,
    output logic          take_in,
    output logic          acc_clr,
    output out_src_t      src,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] LAST_D = CW'(NDATA - 1);
    localparam logic [CW-1:0] LAST_P = CW'(NPAR - 1);

    enc_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          take_out;

    assign cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        src       = SRC_NONE;
        unique case (state_q)
            ST_IDLE, ST_LOAD: in_ready = 1'b1;
            ST_SEND_DATA: begin
                out_valid = 1'b1;
                src       = SRC_DATA;
            end
            ST_SEND_PAR_A: begin
                out_valid = 1'b1;
                src       = SRC_PAR_A;
            end
            ST_SEND_PAR_B: begin
                out_valid = 1'b1;
                src       = SRC_PAR_B;
                out_last  = (cnt_q == LAST_P);
            end
            default: ;
        endcase
        take_in  = in_ready & in_valid;
        take_out = out_valid & out_ready;
        acc_clr  = take_out & out_last;
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_in) begin
                    if (NDATA == 1) begin
                        state_d = ST_SEND_DATA;
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_LOAD;
                        cnt_d   = CW'(1);
                    end
                end
            end
            ST_LOAD: begin
                if (take_in) begin
                    if (cnt_q == LAST_D) begin
                        state_d = ST_SEND_DATA;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            ST_SEND_DATA: begin
                if (take_out) begin
                    if (cnt_q == LAST_D) begin
                        state_d = ST_SEND_PAR_A;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            ST_SEND_PAR_A: begin
                if (take_out) begin
                    if (cnt_q == LAST_P) begin
                        state_d = ST_SEND_PAR_B;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            ST_SEND_PAR_B: begin
                if (take_out) begin
                    if (cnt_q == LAST_P) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

endmodule

// File: rtl/spc_pcc_encoder.sv
module spc_pcc_encoder
    import spc_pcc_pkg::*;
#(
    parameter int                 N_SIDE = 3,
    parameter int                 DIMS   = 2,
    parameter logic [TABLE_W-1:0] PERM   = TABLE_W'(32'h0103_0002)
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    output logic in_ready,
    output logic out_valid,
    output logic out_bit,
    output logic out_last,
    input  logic out_ready
);

    localparam int NDATA = ipow(N_SIDE - 1, DIMS);
    localparam int NPAR  = ipow(N_SIDE, DIMS) - NDATA;
    localparam int MAXC  = (NDATA > NPAR) ? NDATA : NPAR;
    localparam int CW    = $clog2(MAXC + 1);
    localparam int SPAN  = 1 << CW;

    if (N_SIDE < 2 || DIMS < 1 || NDATA > MAX_ENTRIES) begin : g_bad_shape
        $error("spc_pcc_encoder: unsupported N_SIDE/DIMS");
    end
    if (!table_is_perm(PERM, NDATA)) begin : g_bad_table
        $error("spc_pcc_encoder: PERM is not a permutation of the data positions");
    end

    logic            take_in;
    logic            acc_clr;
    out_src_t        src;
    logic [CW-1:0]   cnt;
    logic [SPAN-1:0] data_q;
    logic [SPAN-1:0] par_a;
    logic [SPAN-1:0] par_b;

    spc_pcc_ctrl #(
        .NDATA(NDATA),
        .NPAR (NPAR),
        .CW   (CW)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .out_ready(out_ready),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .out_last (out_last),
        .take_in  (take_in),
        .acc_clr  (acc_clr),
        .src      (src),
        .cnt      (cnt)
    );

    spc_parity_acc #(
        .N_SIDE     (N_SIDE),
        .DIMS       (DIMS),
        .INTERLEAVED(1'b0),
        .PERM       (PERM),
        .CW         (CW)
    ) acc_a_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (acc_clr),
        .upd   (take_in),
        .pos   (cnt),
        .bit_in(in_bit),
        .par_o (par_a)
    );

    spc_parity_acc #(
        .N_SIDE     (N_SIDE),
        .DIMS       (DIMS),
        .INTERLEAVED(1'b1),
        .PERM       (PERM),
        .CW         (CW)
    ) acc_b_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (acc_clr),
        .upd   (take_in),
        .pos   (cnt),
        .bit_in(in_bit),
        .par_o (par_b)
    );

    always_ff @(posedge clk) begin
        if (rst)          data_q <= '0;
        else if (take_in) data_q[cnt] <= in_bit;
    end

    always_comb begin
        unique case (src)
            SRC_DATA:  out_bit = data_q[cnt];
            SRC_PAR_A: out_bit = par_a[cnt];
            SRC_PAR_B: out_bit = par_b[cnt];
            default:   out_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/spc_pcc_encoder_chk.sv
module spc_pcc_encoder_chk
    import spc_pcc_pkg::*;
#(
    parameter int N_SIDE = 3,
    parameter int DIMS   = 2
) (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_bit,
    input logic in_ready,
    input logic out_valid,
    input logic out_bit,
    input logic out_last,
    input logic out_ready
);

    localparam int NDATA = ipow(N_SIDE - 1, DIMS);
    localparam int TOTAL = 2 * ipow(N_SIDE, DIMS) - NDATA;

    int              in_cnt;
    int              out_cnt;
    logic [NDATA-1:0] seen_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_cnt    <= 0;
            out_cnt   <= 0;
            seen_bits <= '0;
        end else begin
            if (in_valid && in_ready) begin
                seen_bits[in_cnt] <= in_bit;
                in_cnt <= (in_cnt == NDATA - 1) ? 0 : in_cnt + 1;
            end
            if (out_valid && out_ready)
                out_cnt <= (out_cnt == TOTAL - 1) ? 0 : out_cnt + 1;
        end
    end

    // R1
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (in_ready && !out_valid && !out_last));

    // R2
    a_r2_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_cnt == NDATA - 1) |=> !in_ready);

    // R2
    a_r2_ready_returns: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

    // R3
    a_r3_last_position: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_last == (out_cnt == TOTAL - 1)));

    // R4
    a_r4_data_echo: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cnt < NDATA) |-> (out_bit == seen_bits[out_cnt]));

    // R7
    a_r7_hold_output: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));

endmodule

bind spc_pcc_encoder spc_pcc_encoder_chk #(
    .N_SIDE(N_SIDE),
    .DIMS  (DIMS)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_bit  (out_bit),
    .out_last (out_last),
    .out_ready(out_ready)
);

// File: tb/spc_pcc_encoder_tb_top.sv
module spc_pcc_encoder_tb_top;

    // defaults n=3, d=2: 4 data bits, 14-bit codeword
    // vector layout {mode[2:0], data[3:0], code[13:0]}
    // mode bit0: input gaps, bit1: output stalls, bit2: junk input while emitting
    localparam logic [20:0] VECS [8] = '{
        {3'b000, 4'h0, 14'h0000},
        {3'b000, 4'h1, 14'h3351},
        {3'b001, 4'hF, 14'h000F},
        {3'b010, 4'h6, 14'h1EF6},
        {3'b100, 4'h8, 14'h2DA8},
        {3'b011, 4'h3, 14'h06C3},
        {3'b110, 4'h5, 14'h1835},
        {3'b111, 4'hD, 14'h359D}
    };

    logic clk = 1'b0;
    logic rst;
    logic in_valid;
    logic in_bit;
    logic in_ready;
    logic out_valid;
    logic out_bit;
    logic out_last;
    logic out_ready;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    spc_pcc_encoder dut_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_bit   (in_bit),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .out_bit  (out_bit),
        .out_last (out_last),
        .out_ready(out_ready)
    );

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // starts and ends at a falling edge
    task automatic run_block(input logic [3:0] d, input logic [2:0] mode,
                             output logic [13:0] code, output int lastpos,
                             output bit hold_ok, output bit ready_low);
        bit   stalled;
        logic held;
        int   nbits;
        code      = '0;
        lastpos   = -1;
        hold_ok   = 1'b1;
        ready_low = 1'b1;
        stalled   = 1'b0;
        held      = 1'b0;
        nbits     = 0;
        for (int i = 0; i < 4; i++) begin
            if (mode[0]) begin
                in_valid = 1'b0;
                in_bit   = ~d[i];
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_bit   = d[i];
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        for (int cyc = 0; cyc < 200 && nbits < 14; cyc++) begin
            out_ready = mode[1] ? (cyc % 3 != 1) : 1'b1;
            if (mode[2]) begin
                in_valid = 1'b1;
                in_bit   = 1'b1;
            end
            if (in_ready) ready_low = 1'b0;
            if (stalled && (!out_valid || out_bit != held)) hold_ok = 1'b0;
            stalled = 1'b0;
            if (out_valid && out_ready) begin
                code[nbits] = out_bit;
                if (out_last) lastpos = nbits;
                nbits++;
                if (out_last) begin
                    @(negedge clk);
                    break;
                end
            end else if (out_valid) begin
                stalled = 1'b1;
                held    = out_bit;
            end
            @(negedge clk);
        end
        in_valid  = 1'b0;
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [13:0] code;
        int          lastpos;
        bit          hold_ok;
        bit          ready_low;

        rst       = 1'b1;
        in_valid  = 1'b0;
        in_bit    = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        check(out_valid == 1'b0 && out_last == 1'b0, "R1 out_valid/out_last",
              int'({out_valid, out_last}), 0);

        foreach (VECS[v]) begin
            run_block(VECS[v][17:14], VECS[v][20:18], code, lastpos, hold_ok, ready_low);
            // R4 data echo, R5 branch-A parity, R6 branch-B parity
            check(code[3:0] == VECS[v][3:0], "R4 data section", int'(code[3:0]),
                  int'(VECS[v][3:0]));
            check(code[8:4] == VECS[v][8:4], "R5 branch-A parity", int'(code[8:4]),
                  int'(VECS[v][8:4]));
            check(code[13:9] == VECS[v][13:9], "R6 branch-B parity", int'(code[13:9]),
                  int'(VECS[v][13:9]));
            // R3 length and last flag
            check(lastpos == 13, "R3 last flag position", lastpos, 13);
            // R2 ready low while emitting, back after last
            check(ready_low, "R2 ready low during output", int'(ready_low), 1);
            check(in_ready == 1'b1, "R2 ready after last", int'(in_ready), 1);
            if (VECS[v][19]) check(hold_ok, "R7 output held under stall", int'(hold_ok), 1);
            if (VECS[v][20]) check(code == VECS[v][13:0], "R8 junk input ignored",
                                   int'(code), int'(VECS[v][13:0]));
            if (VECS[v][18]) check(code == VECS[v][13:0], "R10 input gaps",
                                   int'(code), int'(VECS[v][13:0]));
        end

        // R9 reset in the middle of a block
        in_valid = 1'b1;
        in_bit   = 1'b1;
        @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        rst      = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready && !out_valid, "R9 idle after mid-block reset",
              int'({in_ready, out_valid}), 2);
        run_block(4'h1, 3'b000, code, lastpos, hold_ok, ready_low);
        check(code == 14'h3351, "R9 clean block after reset", int'(code), 'h3351);

        // R8 junk input block followed by a clean one: no carry-over
        run_block(4'hD, 3'b100, code, lastpos, hold_ok, ready_low);
        run_block(4'h0, 3'b000, code, lastpos, hold_ok, ready_low);
        check(code == 14'h0000, "R8 no carry-over into next block", int'(code), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule